// File: doc/BRIEF.md
# Receive Test-Pattern Character Checker

This block checks a received character stream against a locally generated pseudo-random reference while a built-in self-test mode is on. One character arrives per clock when its valid strobe is high. The reference is a maximal-length linear feedback shift register as wide as a character, so one pass through the pattern covers every non-zero character value once, 2^W-1 characters in all (511 for the default 9-bit width).

The checker locks onto the incoming pattern without a handshake. The first usable character after the test enable takes effect becomes the register state, and from then on the reference steps once for every valid character. Each later character is compared with the reference. A disagreement raises a mismatch flag for one clock. A separate one-clock pulse marks the last character of every full pass. The test enable may change at any time relative to the clock; it is brought in through a two-flop synchroniser.

The character input is a stream sink whose ready output is always high. The block never applies back-pressure. A beat is taken on every clock edge where valid is high, and idle cycles neither move the reference nor produce events.

Top module: `rx_bist_checker`

## Requirements
- R1: `bist_en` passes through two flip-flops before it has any effect. A character taken on the first or second rising edge after `bist_en` rises is ignored. A character taken on the third edge is processed.
- R2: While seeking, a valid non-zero character becomes the seed and starts the run. No mismatch is reported for the seed itself.
- R3: The expected character after a character s is {s[W-2:0], s[W-1] ^ s[FB_TAP-1]}. The defaults are W=9 and FB_TAP=5, which gives a period of 2^W-1.
- R4: In a run, each valid character is compared with the expected character. `mis_flag` is high in the clock after that character's edge exactly when the two differ. A mismatch does not resynchronise the reference; it keeps stepping.
- R5: A cycle with `chr_valid` low does not advance the reference or the loop position. Both outputs are low in the following clock.
- R6: Counting the seed as character 1, `loop_pulse` is high for exactly one clock after every (2^W-1)-th valid character.
- R7: While seeking, an all-zero valid character raises `mis_flag` in the next clock and the checker stays in the seeking state.
- R8: After a fall of `bist_en` has passed through the two flops, the outputs stay low and the checker returns to seeking. A later enable seeds again from a fresh character.
- R9: While `rst_n` is low, both outputs are low and the checker is seeking.
- R10: `chr_ready` is high at all times, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Test enable, asynchronous to clk |
| chr_valid | input | 1 | Character beat strobe |
| chr_ready | output | 1 | Sink ready, always high |
| chr_data | input | CHAR_W | Received character |
| mis_flag | output | 1 | One-clock mismatch indication |
| loop_pulse | output | 1 | One-clock end-of-pass pulse |

## Verification
The bench builds two instances. The first uses the defaults (W=9, tap 5). It runs two full 511-character passes, so the wrap from the last loop position back to zero is seen twice, and it also exercises seeding, error injection, the zero seed and the enable timing. The second uses W=4 with tap 3, giving a 15-character pass. That makes several wraps cheap to reach, including wraps with idle gaps between valid characters.

// File: rtl/rx_bist_pkg.sv
`timescale 1ns/1ps
package rx_bist_pkg;
  typedef enum logic {ST_SEEK = 1'b0, ST_RUN = 1'b1} chk_state_e;
endpackage

// File: rtl/bist_en_sync.sv
`timescale 1ns/1ps
module bist_en_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bist_ref_lfsr.sv
`timescale 1ns/1ps
module bist_ref_lfsr #(
  parameter int W      = 9,
  parameter int FB_TAP = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  output logic [W-1:0] exp_q
);
  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[FB_TAP-1]};
  endfunction

  // Reference holds the character expected on the next valid beat.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    exp_q <= '1;
    else if (load) exp_q <= step(load_val);
    else if (adv)  exp_q <= step(exp_q);
endmodule

// File: rtl/bist_loop_ctr.sv
`timescale 1ns/1ps
module bist_loop_ctr #(
  parameter int LEN = 511
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic seed,
  input  logic adv,
  output logic wrap
);
  localparam int CW = $clog2(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] pos_q;

  assign wrap = adv && (pos_q == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pos_q <= '0;
    else if (clr)    pos_q <= '0;
    else if (seed)   pos_q <= CW'(1);
    else if (wrap)   pos_q <= '0;
    else if (adv)    pos_q <= pos_q + CW'(1);
endmodule

// File: rtl/rx_bist_checker.sv
`timescale 1ns/1ps
module rx_bist_checker
  import rx_bist_pkg::*;
#(
  parameter int CHAR_W = 9,
  parameter int FB_TAP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic              chr_valid,
  output logic              chr_ready,
  input  logic [CHAR_W-1:0] chr_data,
  output logic              mis_flag,
  output logic              loop_pulse
);
  localparam int LOOP_LEN = (1 << CHAR_W) - 1;

  logic              en_sync;
  chk_state_e        state;
  logic [CHAR_W-1:0] exp_q;
  logic              do_seed, do_adv, wrap;
  logic              mis_nxt;

  bist_en_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(bist_en), .q_sync(en_sync)
  );

  always_comb begin
    do_seed = 1'b0;
    do_adv  = 1'b0;
    mis_nxt = 1'b0;
    if (en_sync && chr_valid) begin
      if (state == ST_SEEK) begin
        do_seed = (chr_data != '0);
        mis_nxt = (chr_data == '0);
      end else begin
        do_adv  = 1'b1;
        mis_nxt = (chr_data != exp_q);
      end
    end
  end

  bist_ref_lfsr #(.W(CHAR_W), .FB_TAP(FB_TAP)) u_ref (
    .clk(clk), .rst_n(rst_n), .load(do_seed), .load_val(chr_data),
    .adv(do_adv), .exp_q(exp_q)
  );

  bist_loop_ctr #(.LEN(LOOP_LEN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(!en_sync), .seed(do_seed),
    .adv(do_adv), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_SEEK;
      mis_flag   <= 1'b0;
      loop_pulse <= 1'b0;
    end else if (!en_sync) begin
      state      <= ST_SEEK;
      mis_flag   <= 1'b0;
      loop_pulse <= 1'b0;
    end else begin
      if (do_seed) state <= ST_RUN;
      mis_flag   <= mis_nxt;
      loop_pulse <= wrap;
    end

  assign chr_ready = 1'b1;
endmodule

module rx_bist_checker_sva
  import rx_bist_pkg::*;
#(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic         chr_valid,
  input logic [W-1:0] chr_data,
  input logic         mis_flag,
  input logic         loop_pulse,
  input logic         en_sync,
  input chk_state_e   state,
  input logic [W-1:0] exp_q
);
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    loop_pulse |=> !loop_pulse);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chr_valid |=> (!mis_flag && !loop_pulse));

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_sync |=> (!mis_flag && !loop_pulse && state == ST_SEEK));

  a_r7_zero_seed_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sync && state == ST_SEEK && chr_valid && chr_data == '0)
      |=> (mis_flag && state == ST_SEEK));

  a_r3_ref_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) |-> (exp_q != '0));
endmodule

bind rx_bist_checker rx_bist_checker_sva #(.W(CHAR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
  .mis_flag(mis_flag), .loop_pulse(loop_pulse), .en_sync(en_sync),
  .state(state), .exp_q(exp_q)
);

// File: tb/test_rx_bist_checker.sv
`timescale 1ns/1ps
module test_rx_bist_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Default instance, 9-bit
  logic       en9 = 0, v9 = 0;
  logic [8:0] d9 = '0;
  logic       rdy9, m9, l9;
  // Small instance, 4-bit
  logic       en4 = 0, v4 = 0;
  logic [3:0] d4 = '0;
  logic       rdy4, m4, l4;

  rx_bist_checker i_rx_bist_checker (
    .clk(clk), .rst_n(rst_n), .bist_en(en9), .chr_valid(v9), .chr_ready(rdy9),
    .chr_data(d9), .mis_flag(m9), .loop_pulse(l9));

  rx_bist_checker #(.CHAR_W(4), .FB_TAP(3)) i_rx_bist_checker_small (
    .clk(clk), .rst_n(rst_n), .bist_en(en4), .chr_valid(v4), .chr_ready(rdy4),
    .chr_data(d4), .mis_flag(m4), .loop_pulse(l4));

  function automatic logic [8:0] nx9(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction
  function automatic logic [3:0] nx4(input logic [3:0] s);
    return {s[2:0], s[3] ^ s[2]};
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step9(input logic v, input logic [8:0] d, input logic em,
                       input logic el, input string tag);
    @(negedge clk); v9 = v; d9 = d;
    @(posedge clk); #1;
    chk(m9, em, {tag, " mis_flag"});
    chk(l9, el, {tag, " loop_pulse"});
  endtask

  task automatic step4(input logic v, input logic [3:0] d, input logic em,
                       input logic el, input string tag);
    @(negedge clk); v4 = v; d4 = d;
    @(posedge clk); #1;
    chk(m4, em, {tag, " mis_flag"});
    chk(l4, el, {tag, " loop_pulse"});
  endtask

  task automatic resync9();
    en9 = 0;
    repeat (4) step9(0, '0, 0, 0, "R8 off");
    en9 = 1;
    repeat (4) step9(0, '0, 0, 0, "R1 settle");
  endtask

  task automatic resync4();
    en4 = 0;
    repeat (4) step4(0, '0, 0, 0, "R8 off");
    en4 = 1;
    repeat (4) step4(0, '0, 0, 0, "R1 settle");
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk(m9, 0, "R9 reset mis");
    chk(l9, 0, "R9 reset loop");
    chk(rdy9, 1, "R10 ready in reset");
    rst_n = 1;
    repeat (2) @(posedge clk);
    #1;
    chk(rdy9, 1, "R10 ready after reset");
    chk(rdy4, 1, "R10 ready small");
  endtask

  // R1: zero chars right as enable rises; only the third edge sees them.
  task automatic t_enable_sync();
    en9 = 0;
    repeat (4) step9(0, '0, 0, 0, "R1 pre");
    en9 = 1;
    step9(1, '0, 0, 0, "R1 edge1 ignored");
    step9(1, '0, 0, 0, "R1 edge2 ignored");
    step9(1, '0, 1, 0, "R1 edge3 processed R7");
    step9(0, '0, 0, 0, "R5 idle");
  endtask

  // R2 R3 R6: two clean passes from an all-ones seed.
  task automatic t_clean_run();
    logic [8:0] s = 9'h1FF;
    resync9();
    for (int i = 0; i < 1022; i++) begin
      step9(1, s, 0, ((i + 1) % 511) == 0, "R6 R3 R2 clean");
      s = nx9(s);
    end
    step9(0, '0, 0, 0, "R5 after run");
  endtask

  // R4: injected error flagged once, reference keeps stepping.
  task automatic t_error_inject();
    logic [8:0] s = 9'h0A5;
    resync9();
    for (int i = 0; i < 20; i++) begin
      if (i == 7 || i == 12)
        step9(1, s ^ 9'h001, 1, 0, "R4 injected");
      else
        step9(1, s, 0, 0, "R4 clean neighbour");
      s = nx9(s);
    end
  endtask

  // R5: idle cycles with garbage data do not advance or flag.
  task automatic t_gaps();
    logic [8:0] s = 9'h123;
    resync9();
    for (int i = 0; i < 24; i++) begin
      step9(1, s, 0, 0, "R5 valid beat");
      step9(0, ~s, 0, 0, "R5 idle beat");
      s = nx9(s);
    end
  endtask

  // R7: zero seed rejected, stays seeking, then seeds.
  task automatic t_zero_seed();
    logic [8:0] s = 9'h04C;
    resync9();
    step9(1, '0, 1, 0, "R7 zero 1");
    step9(1, '0, 1, 0, "R7 zero 2");
    step9(1, s, 0, 0, "R2 seed after zero");
    s = nx9(s);
    step9(1, s, 0, 0, "R4 first compare");
    s = nx9(s);
    step9(1, ~s, 1, 0, "R4 locked after zero");
  endtask

  // R8: disable mid-run, two-edge lag, then quiet, then fresh seed.
  task automatic t_disable();
    logic [8:0] s = 9'h155;
    resync9();
    for (int i = 0; i < 5; i++) begin
      step9(1, s, 0, 0, "R8 pre-run");
      s = nx9(s);
    end
    en9 = 0;
    step9(1, ~s, 1, 0, "R8 lag edge1");
    step9(1, ~s, 1, 0, "R8 lag edge2");
    for (int i = 0; i < 6; i++) step9(1, 9'h0F0 + 9'(i), 0, 0, "R8 quiet");
    en9 = 1;
    repeat (4) step9(0, '0, 0, 0, "R1 settle");
    s = 9'h0B2;
    step9(1, s, 0, 0, "R8 reseed");
    for (int i = 0; i < 5; i++) begin
      s = nx9(s);
      step9(1, s, 0, 0, "R8 fresh run");
    end
  endtask

  // R6: short pass, several wraps, with gaps every third beat.
  task automatic t_small_wraps();
    logic [3:0] s = 4'h1;
    int n = 0;
    resync4();
    for (int i = 0; i < 45; i++) begin
      n++;
      step4(1, s, 0, (n % 15) == 0, "R6 small wrap");
      s = nx4(s);
      if (i % 3 == 2) step4(0, 4'h0, 0, 0, "R5 small gap");
    end
    step4(1, ~s, 1, 0, "R4 small mismatch");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enable_sync();
    t_clean_run();
    t_error_inject();
    t_gaps();
    t_zero_seed();
    t_disable();
    t_small_wraps();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule